// File: doc/BRIEF.md
# Descriptor Ring Producer with Loop Stamp

This block owns the write side of a circular descriptor ring held in a register array, and also presents the matching read side to a local consumer. Each accepted descriptor is eight 32-bit words wide and is stored in one cycle. Before storage, the top four bits of the final word are overwritten with the producer's loop count. The loop count records how many times the write index has wrapped around the ring.

The consumer never reads a head pointer. It keeps an expected parity bit that starts at 0 and flips each time its own read index wraps. A slot is new when the low bit of its stored loop stamp equals that parity. At reset every slot is filled with stamp 15, so no slot looks new before the first pass. The producer holds ready low rather than overwrite a slot that has not been popped.

Descriptors flagged as internally errored skip the main ring. They go into a small separate error ring, and their top four bits pass through unchanged because they carry an error code.

Top module: `ring_wrap_producer`

## Requirements
- R1: After reset, in_ready is 1, full is 0, rd_valid is 0 and err_valid is 0; no slot appears new before the first write.
- R2: A main-ring descriptor reads back on rd_data with bits [ENTRY_W-1:ENTRY_W-4] (bits [31:28] of word 7, the last word) replaced by the loop stamp. All other bits are unchanged.
- R3: The loop stamp is 0 during the first pass and increases by one at each write-index wrap. After 15 it returns to 0.
- R4: rd_valid is 1 exactly when the slot at the read index holds a stamp whose low bit equals the consumer parity. The parity starts at 0 and flips when the read index wraps. Descriptors are delivered in write order, and rd_pop with rd_valid high advances to the next one.
- R5: full is 1 when DEPTH descriptors are unpopped. While full, in_ready is 0 for non-error descriptors, and a descriptor offered then is not stored.
- R6: rd_pop while rd_valid is 0 has no effect.
- R7: A descriptor with in_err high goes to the error ring with all bits unchanged, including its top four error-code bits. It does not occupy the main ring and does not advance the loop stamp.
- R8: The error ring returns descriptors in order on err_data and err_valid, and err_pop removes one. When it holds ERR_DEPTH entries, in_ready is 0 for errored descriptors. err_pop on an empty error ring is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor offered |
| in_err | input | 1 | Offered descriptor is flagged as errored |
| in_data | input | ENTRY_W | Descriptor, word k in bits [32k+31:32k] |
| in_ready | output | 1 | Descriptor accepted this cycle when in_valid is high |
| full | output | 1 | Main ring holds DEPTH unpopped descriptors |
| rd_valid | output | 1 | Slot at the read index is new |
| rd_data | output | ENTRY_W | Descriptor at the read index |
| rd_pop | input | 1 | Consume the current main-ring descriptor |
| err_valid | output | 1 | Error ring not empty |
| err_data | output | ENTRY_W | Oldest errored descriptor |
| err_pop | input | 1 | Consume the oldest errored descriptor |

## Verification
The bench builds the block with DEPTH 4 and ERR_DEPTH 2. With these values a full main ring or a full error ring is only a few pushes away, so stalls and rejected offers occur often under random traffic. The small depth also means the four-bit stamp passes through all sixteen values, and back from 15 to 0, after 64 main-ring writes. This lets a short run cover the wrap of the stamp and many flips of the consumer parity.

// File: rtl/rwp_pkg.sv
package rwp_pkg;
  localparam int LOOP_W = 4;
  typedef logic [LOOP_W-1:0] loop_t;
  // slots start with all-ones stamp: low bit 1 never matches initial parity 0
  localparam loop_t LOOP_SLOT_INIT = '1;

  function automatic loop_t loop_next(input loop_t c);
    return loop_t'(c + loop_t'(1));
  endfunction

  function automatic logic slot_is_fresh(input loop_t stamp, input logic parity);
    return stamp[0] == parity;
  endfunction
endpackage

// File: rtl/rwp_wr_ctrl.sv
module rwp_wr_ctrl
  import rwp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output loop_t            loop_cnt,
  output logic             wr_wrap
);
  assign wr_wrap = wr_en && (wr_idx == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx   <= '0;
      loop_cnt <= '0;
    end else if (wr_en) begin
      wr_idx <= wr_wrap ? '0 : wr_idx + IDX_W'(1);
      if (wr_wrap) loop_cnt <= loop_next(loop_cnt);
    end
  end
endmodule

// File: rtl/rwp_rd_ctrl.sv
module rwp_rd_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_ok,
  output logic [IDX_W-1:0] rd_idx,
  output logic             exp_lsb
);
  logic rd_wrap;
  assign rd_wrap = pop_ok && (rd_idx == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx  <= '0;
      exp_lsb <= 1'b0;
    end else if (pop_ok) begin
      rd_idx <= rd_wrap ? '0 : rd_idx + IDX_W'(1);
      if (rd_wrap) exp_lsb <= !exp_lsb;
    end
  end
endmodule

// File: rtl/rwp_slot_mem.sv
module rwp_slot_mem
  import rwp_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int ENTRY_W = 256,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic [IDX_W-1:0]   raddr,
  output logic [ENTRY_W-1:0] rdata
);
  logic [ENTRY_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENTRY_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                q <= {LOOP_SLOT_INIT, {(ENTRY_W-LOOP_W){1'b0}}};
      else if (we && waddr == IDX_W'(g))         q <= wdata;
    end
    assign slot_q[g] = q;
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/rwp_err_ring.sv
module rwp_err_ring #(
  parameter int ERR_DEPTH = 4,
  parameter int ENTRY_W   = 256,
  localparam int EIDX_W   = $clog2(ERR_DEPTH),
  localparam int ECNT_W   = $clog2(ERR_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [ENTRY_W-1:0] push_data,
  input  logic               pop,
  output logic               not_empty,
  output logic               is_full,
  output logic [ENTRY_W-1:0] head_data
);
  logic [ENTRY_W-1:0] mem [ERR_DEPTH];
  logic [EIDX_W-1:0]  wp, rp;
  logic [ECNT_W-1:0]  cnt;
  logic               pop_eff;

  assign not_empty = cnt != '0;
  assign is_full   = cnt == ECNT_W'(ERR_DEPTH);
  assign pop_eff   = pop && not_empty;
  assign head_data = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)    wp <= (wp == EIDX_W'(ERR_DEPTH - 1)) ? '0 : wp + EIDX_W'(1);
      if (pop_eff) rp <= (rp == EIDX_W'(ERR_DEPTH - 1)) ? '0 : rp + EIDX_W'(1);
      case ({push, pop_eff})
        2'b10:   cnt <= cnt + ECNT_W'(1);
        2'b01:   cnt <= cnt - ECNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ring_wrap_producer.sv
module ring_wrap_producer
  import rwp_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ERR_DEPTH = 4,
  parameter int WORDS     = 8,
  parameter int WORD_W    = 32,
  localparam int ENTRY_W  = WORDS * WORD_W,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int OCC_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_err,
  input  logic [ENTRY_W-1:0] in_data,
  output logic               in_ready,
  output logic               full,
  output logic               rd_valid,
  output logic [ENTRY_W-1:0] rd_data,
  input  logic               rd_pop,
  output logic               err_valid,
  output logic [ENTRY_W-1:0] err_data,
  input  logic               err_pop
);
  // named internal events, observed by the bound checker
  logic               main_wr, err_wr, pop_ok, wr_wrap, exp_lsb, err_full;
  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [OCC_W-1:0]   occupancy;
  loop_t              loop_cnt, slot_stamp;
  logic [ENTRY_W-1:0] slot_q, stamped;

  assign full       = occupancy == OCC_W'(DEPTH);
  assign in_ready   = in_err ? !err_full : !full;
  assign main_wr    = in_valid && !in_err && !full;
  assign err_wr     = in_valid && in_err && !err_full;
  assign stamped    = {loop_cnt, in_data[ENTRY_W-LOOP_W-1:0]};
  assign slot_stamp = slot_q[ENTRY_W-1 -: LOOP_W];
  assign rd_valid   = slot_is_fresh(slot_stamp, exp_lsb);
  assign pop_ok     = rd_pop && rd_valid;
  assign rd_data    = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occupancy <= '0;
    else begin
      case ({main_wr, pop_ok})
        2'b10:   occupancy <= occupancy + OCC_W'(1);
        2'b01:   occupancy <= occupancy - OCC_W'(1);
        default: occupancy <= occupancy;
      endcase
    end
  end

  rwp_wr_ctrl #(.DEPTH(DEPTH)) wr_ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(main_wr),
    .wr_idx(wr_idx), .loop_cnt(loop_cnt), .wr_wrap(wr_wrap)
  );

  rwp_rd_ctrl #(.DEPTH(DEPTH)) rd_ctrl_i (
    .clk(clk), .rst_n(rst_n), .pop_ok(pop_ok),
    .rd_idx(rd_idx), .exp_lsb(exp_lsb)
  );

  rwp_slot_mem #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) slot_mem_i (
    .clk(clk), .rst_n(rst_n), .we(main_wr), .waddr(wr_idx),
    .wdata(stamped), .raddr(rd_idx), .rdata(slot_q)
  );

  rwp_err_ring #(.ERR_DEPTH(ERR_DEPTH), .ENTRY_W(ENTRY_W)) err_ring_i (
    .clk(clk), .rst_n(rst_n), .push(err_wr), .push_data(in_data),
    .pop(err_pop), .not_empty(err_valid), .is_full(err_full), .head_data(err_data)
  );
endmodule

// File: rtl/rwp_checker.sv
module rwp_checker
  import rwp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_err,
  input logic             in_ready,
  input logic             full,
  input logic             rd_valid,
  input logic             rd_pop,
  input logic             main_wr,
  input logic             err_wr,
  input logic             pop_ok,
  input logic             wr_wrap,
  input logic             exp_lsb,
  input loop_t            loop_cnt,
  input logic [IDX_W-1:0] rd_idx,
  input logic [OCC_W-1:0] occupancy
);
  assert_ready_low_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full && !in_err |-> !in_ready);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(DEPTH));

  assert_fresh_tracks_occupancy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == (occupancy != '0));

  assert_parity_flips_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && rd_idx == IDX_W'(DEPTH - 1) |=> exp_lsb != $past(exp_lsb));

  assert_loop_steps_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wrap |=> loop_cnt == loop_next($past(loop_cnt)));

  assert_loop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wrap |=> loop_cnt == $past(loop_cnt));

  assert_ignored_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop && !rd_valid && !main_wr |=> occupancy == $past(occupancy));

  assert_err_bypasses_main_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr |-> !main_wr);

  assert_err_keeps_occupancy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr && !pop_ok |=> occupancy == $past(occupancy));
endmodule

bind ring_wrap_producer rwp_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_err(in_err), .in_ready(in_ready), .full(full),
  .rd_valid(rd_valid), .rd_pop(rd_pop), .main_wr(main_wr), .err_wr(err_wr),
  .pop_ok(pop_ok), .wr_wrap(wr_wrap), .exp_lsb(exp_lsb), .loop_cnt(loop_cnt),
  .rd_idx(rd_idx), .occupancy(occupancy)
);

// File: tb/ring_wrap_producer_tb_top.sv
module ring_wrap_producer_tb_top;
  localparam int CLK_P     = 10;
  localparam int DEPTH     = 4;
  localparam int ERR_DEPTH = 2;
  localparam int ENTRY_W   = 256;
  localparam int SEED      = 1234;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_err = 1'b0, rd_pop = 1'b0, err_pop = 1'b0;
  logic [ENTRY_W-1:0] in_data = '0;
  logic in_ready, full, rd_valid, err_valid;
  logic [ENTRY_W-1:0] rd_data, err_data;

  always #(CLK_P/2) clk = ~clk;

  ring_wrap_producer #(.DEPTH(DEPTH), .ERR_DEPTH(ERR_DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_err(in_err), .in_data(in_data),
    .in_ready(in_ready), .full(full), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_pop(rd_pop), .err_valid(err_valid), .err_data(err_data), .err_pop(err_pop)
  );

  int checks = 0, errors = 0;
  logic [ENTRY_W-1:0] mq[$];
  logic [ENTRY_W-1:0] eq[$];
  int       b_widx = 0;
  bit [3:0] b_loop = 0;
  int       prev_stamp = -1;
  int       wrap_15_to_0 = 0;
  bit       done = 0;

  function automatic logic [ENTRY_W-1:0] with_stamp(logic [ENTRY_W-1:0] d, bit [3:0] s);
    logic [ENTRY_W-1:0] r = d;
    r[ENTRY_W-1:ENTRY_W-4] = s;
    return r;
  endfunction

  function automatic logic [ENTRY_W-1:0] rnd_entry();
    logic [ENTRY_W-1:0] r;
    for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom();
    return r;
  endfunction

  task automatic check(string req, logic [ENTRY_W-1:0] act, logic [ENTRY_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check outputs of the current state, update model for next edge
  task automatic step(bit v, bit e, logic [ENTRY_W-1:0] d, bit p, bit ep);
    bit exp_ready, pop_m, pop_e;
    in_valid = v; in_err = e; in_data = d; rd_pop = p; err_pop = ep;
    #1;
    exp_ready = e ? (eq.size() < ERR_DEPTH) : (mq.size() < DEPTH);
    check(e ? "R8" : "R5", in_ready, exp_ready);
    check("R5", full, mq.size() == DEPTH);
    check("R4", rd_valid, mq.size() > 0);
    if (mq.size() > 0) check("R2", rd_data, mq[0]);
    check("R8", err_valid, eq.size() > 0);
    if (eq.size() > 0) check("R7", err_data, eq[0]);
    pop_m = p && mq.size() > 0;
    pop_e = ep && eq.size() > 0;
    if (pop_m) begin
      int s = int'(mq[0][ENTRY_W-1:ENTRY_W-4]);
      if (prev_stamp == 15 && s == 0) wrap_15_to_0++;
      prev_stamp = s;
      void'(mq.pop_front());
    end
    if (pop_e) void'(eq.pop_front());
    if (v && exp_ready) begin
      if (e) eq.push_back(d);
      else begin
        mq.push_back(with_stamp(d, b_loop));
        b_widx++;
        if (b_widx == DEPTH) begin b_widx = 0; b_loop = b_loop + 4'd1; end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ENTRY_W-1:0] d;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", {in_ready, full, rd_valid, err_valid}, 4'b1000);

    // R6 pop on empty ring is ignored
    step(0, 0, '0, 1, 1);
    step(0, 0, '0, 0, 0);
    check("R6", rd_valid, 1'b0);

    // R5 fill, offer one more, then drain
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, rnd_entry(), 0, 0);
    check("R5", full, 1'b1);
    for (int i = 0; i < DEPTH; i++) step(0, 0, '0, 1, 0);
    check("R5", rd_valid, 1'b0);

    // R7 errored descriptors keep their code bits; third one stalls (R8)
    for (int i = 0; i < ERR_DEPTH + 1; i++) begin
      d = rnd_entry(); d[ENTRY_W-1:ENTRY_W-4] = 4'hA;
      step(1, 1, d, 0, 0);
    end
    check("R7", err_data[ENTRY_W-1:ENTRY_W-4], 4'hA);
    step(1, 0, rnd_entry(), 0, 0);
    check("R7", rd_data[ENTRY_W-1:ENTRY_W-4], 4'd1);
    for (int i = 0; i < ERR_DEPTH + 1; i++) step(0, 0, '0, 1, 1);
    check("R8", err_valid, 1'b0);

    // R3 run many passes to see the stamp return from 15 to 0
    for (int i = 0; i < DEPTH * 18; i++) begin
      step(1, 0, rnd_entry(), 0, 0);
      step(0, 0, '0, 1, 0);
    end
    check("R3", wrap_15_to_0 > 0, 1'b1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit v = ($urandom() % 4) != 0;
      bit e = ($urandom() % 5) == 0;
      bit p = ($urandom() % 3) != 0;
      bit ep = ($urandom() % 2) != 0;
      step(v, e, rnd_entry(), p, ep);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule